// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a clocked host and an external byte-wide asynchronous static RAM with 2^19 locations. The host issues single-beat requests: an address, a write flag and, for writes, one data byte. The block turns each request into a sequence of active-low chip-enable, write-enable and output-enable levels that meet the memory's minimum pulse, setup, access and bus-release times. Read results come back as a one-cycle pulse with the captured byte.

The length of each timing phase is computed at elaboration from the memory's nanosecond figures and the clock period, rounded up to whole cycles and never less than one. With the default 10 ns clock this gives a 3-cycle write pulse, a chip-enable lead of 3 cycles before write enable falls (so chip enable is low 6 cycles up to the end of the write), a 6-cycle read access and a 3-cycle bus turnaround after a read. The shared data pins are modelled as separate out, in and drive-enable signals. The block only drives the pins while output enable is high, and it leaves a turnaround gap after every read before it drives again.

The request port follows valid/ready. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no access is in flight, and the host must hold its request stable while `req_valid` is high and `req_ready` is low. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the host must take the byte in that cycle.

Top module: `asram_ctl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: Exactly one access is started per accepting edge. `req_ready` is 0 from the edge after acceptance until the access is complete, and is never 1 while `mem_ce_n` is 0.
- R3: A write holds `mem_we_n` at 0 for exactly WP cycles (default 3). `mem_ce_n` is already 0 in the cycle before `mem_we_n` falls, and has been 0 for WP+LEAD cycles (default 6) when `mem_we_n` rises.
- R4: While `mem_we_n` is 0, `mem_oe_n` is 1, `mem_dq_oe` is 1, and `mem_dq_out` carries the request's data byte.
- R5: `mem_addr` changes only in a cycle where both `mem_ce_n` and `mem_we_n` are 1 in that cycle and in the one before.
- R6: In the cycle after `mem_we_n` rises, `mem_dq_oe` is still 1 and `mem_addr` is unchanged (data and address hold).
- R7: A read holds `mem_ce_n` and `mem_oe_n` at 0 together for exactly ACC cycles (default 6), with `mem_we_n` at 1 and `mem_dq_oe` at 0. `rsp_valid` pulses for one cycle, ACC+1 edges after the accepting edge, and carries the `mem_dq_in` byte from the last cycle of that window.
- R8: After `mem_oe_n` rises, `mem_dq_oe` stays 0 for at least TURN cycles (default 3).
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R10: A read returns the byte most recently written to that address, including addresses 0 and 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-result pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 8 | Byte driven towards the memory |
| mem_dq_in | input | 8 | Byte read from the memory pins |
| mem_dq_oe | output | 1 | Controller drives the data pins |

## Verification
The bench memory model returns the inverted byte until the access count has fully elapsed. A sequencer that samples early therefore returns wrong data instead of passing by luck. The model keeps a driving tail after output enable rises, so a write that follows a read too closely shows up as bus contention. Pulse and chip-enable lead lengths are measured at the pins, so a short write strobe, or a write enable that falls together with chip enable, is caught even when the data still lands. Boundary addresses and back-to-back read/write mixes expose an address that moves under a strobe, or a drive released before write enable rises, as corrupted read-back.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_ADDR,
    ST_W_CE,
    ST_W_PULSE,
    ST_W_END,
    ST_R_ADDR,
    ST_R_ACC,
    ST_R_TURN
  } seq_state_e;

  // whole cycles covering a time, never below one
  function automatic int cyc_of(input int t_ns, input int period_ns);
    int c;
    c = (t_ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3/R7/R8 phase lengths rely on an expired timer staying expired
  a_r3_timer_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int WP_C   = 3,
  parameter int LEAD_C = 3,
  parameter int ACC_C  = 6,
  parameter int TURN_C = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       req_ready,
  output logic       accept,
  output logic       capture,
  output seq_state_e state_nxt
);

  localparam int MAXC  = max2(max2(WP_C, LEAD_C), max2(ACC_C, TURN_C));
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WP_C - 1);
  localparam logic [CNT_W-1:0] LD_LEAD = CNT_W'(LEAD_C - 1);
  localparam logic [CNT_W-1:0] LD_ACC  = CNT_W'(ACC_C - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_C - 1);

  seq_state_e       state_q;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_zero;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_nxt = state_q;
    t_load    = 1'b0;
    t_val     = '0;
    capture   = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (req_valid) state_nxt = req_write ? ST_W_ADDR : ST_R_ADDR;
      ST_W_ADDR: begin
        state_nxt = ST_W_CE;
        t_load    = 1'b1;
        t_val     = LD_LEAD;
      end
      ST_W_CE:
        if (t_zero) begin
          state_nxt = ST_W_PULSE;
          t_load    = 1'b1;
          t_val     = LD_WP;
        end
      ST_W_PULSE:
        if (t_zero) state_nxt = ST_W_END;
      ST_W_END:
        state_nxt = ST_IDLE;
      ST_R_ADDR: begin
        state_nxt = ST_R_ACC;
        t_load    = 1'b1;
        t_val     = LD_ACC;
      end
      ST_R_ACC:
        if (t_zero) begin
          state_nxt = ST_R_TURN;
          capture   = 1'b1;
          t_load    = 1'b1;
          t_val     = LD_TURN;
        end
      ST_R_TURN:
        if (t_zero) state_nxt = ST_IDLE;
      default:
        state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nxt;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r7_capture_once: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

endmodule

// File: rtl/asram_pin_drive.sv
module asram_pin_drive
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  seq_state_e        state_nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic ce_d, we_d, oe_d, drv_d;

  // strobe levels (active high here) for the state about to be entered
  always_comb begin
    ce_d  = (state_nxt == ST_W_CE) || (state_nxt == ST_W_PULSE) ||
            (state_nxt == ST_R_ACC);
    we_d  = (state_nxt == ST_W_PULSE);
    oe_d  = (state_nxt == ST_R_ACC);
    drv_d = (state_nxt == ST_W_PULSE) || (state_nxt == ST_W_END);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      mem_ce_n  <= !ce_d;
      mem_we_n  <= !we_d;
      mem_oe_n  <= !oe_d;
      mem_dq_oe <= drv_d;
      rsp_valid <= capture;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

  a_r4_write_owns_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe));

  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r5_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n || !mem_we_n || !$past(mem_ce_n) || !$past(mem_we_n))
      |-> $stable(mem_addr));

  a_r3_ce_leads_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n));

  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_WP_NS       = 30,
  parameter int T_DW_NS       = 25,
  parameter int T_WC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OHZ_NS      = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int WP_C   = max2(cyc_of(T_WP_NS, CLK_PERIOD_NS),
                               cyc_of(T_DW_NS, CLK_PERIOD_NS));
  localparam int WC_C   = cyc_of(T_WC_NS, CLK_PERIOD_NS);
  localparam int LEAD_C = (WC_C > WP_C) ? (WC_C - WP_C) : 1;
  localparam int ACC_C  = cyc_of(T_AA_NS, CLK_PERIOD_NS);
  localparam int TURN_C = cyc_of(T_OHZ_NS, CLK_PERIOD_NS);

  logic       accept;
  logic       capture;
  seq_state_e state_nxt;

  asram_seq #(
    .WP_C   (WP_C),
    .LEAD_C (LEAD_C),
    .ACC_C  (ACC_C),
    .TURN_C (TURN_C)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .state_nxt (state_nxt)
  );

  asram_pin_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .state_nxt  (state_nxt),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  a_r2_no_ready_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

endmodule

// File: tb/asram_ctl_test.sv
module asram_ctl_test;

  localparam int AW   = 19;
  localparam int DW   = 8;
  localparam int WP   = 3;   // ceil(30/10)
  localparam int CEW  = 6;   // ceil(55/10): chip enable low up to end of write
  localparam int ACC  = 6;   // ceil(55/10)
  localparam int TURN = 3;   // ceil(25/10)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;

  always #10 clk = ~clk;

  asram_ctl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  bit run_pins = 1'b0;

  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] exp_q[$];
  int            t_q[$];
  int            wr_issued = 0, rd_issued = 0, we_falls = 0, rsp_seen = 0;

  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int t;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      if (req_ready) begin
        t = ncyc;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (wr) begin
      shadow[int'(a)] = d;
      wr_issued++;
    end else begin
      exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
      t_q.push_back(t);
      rd_issued++;
    end
  endtask

  // memory model and pin monitor
  logic [DW-1:0] model [int];
  bit            p_ce_n = 1, p_we_n = 1, p_oe_n = 1, p_drive = 0, p_wr = 0, p_dq_oe = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;
  int            rd_cnt = 0, tail = 0, we_run = 0, ce_run = 0, oe_run = 0;

  always @(negedge clk) begin
    bit           drive;
    logic [DW-1:0] v;
    if (run_pins) begin
      drive = !mem_ce_n && mem_we_n && !mem_oe_n;
      // R9 / R8: no drive while the memory drives or during its release tail
      if (mem_dq_oe && (drive || tail > 0))
        chk(1'b0, "R9", "dq_oe during memory drive", 1, 0);
      if (mem_dq_oe && !p_dq_oe)
        chk(tail == 0, "R8", "turnaround tail at drive start", tail, 0);
      if (!p_drive || drive) begin
        if (tail > 0) tail--;
      end else tail = TURN;
      // write capture at end of overlap
      if (p_wr && !(!mem_ce_n && !mem_we_n)) model[int'(p_addr)] = p_dq;
      p_wr = !mem_ce_n && !mem_we_n;
      p_dq = mem_dq_oe ? mem_dq_out : ~mem_dq_out;
      // read data is valid only once the full access count elapsed
      rd_cnt = drive ? rd_cnt + 1 : 0;
      v = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00;
      mem_dq_in <= drive ? ((rd_cnt >= ACC) ? v : ~v) : 8'h00;
      // R2
      if (!mem_ce_n && req_ready) chk(1'b0, "R2", "ready while selected", 1, 0);
      // R5
      if (mem_addr != p_addr)
        chk(mem_ce_n && mem_we_n && p_ce_n && p_we_n, "R5", "addr moved under strobe",
            int'(mem_addr), int'(p_addr));
      ce_run = mem_ce_n ? 0 : ce_run + 1;
      // R3 / R4 / R6 write strobe
      if (!mem_we_n && p_we_n) begin
        we_falls++;
        chk(!p_ce_n, "R3", "ce low before we falls", int'(p_ce_n), 0);
      end
      if (!mem_we_n) begin
        we_run++;
        chk(mem_oe_n && mem_dq_oe, "R4", "oe high and drive during write",
            {mem_oe_n, mem_dq_oe}, 3);
      end
      if (mem_we_n && !p_we_n) begin
        chk(we_run == WP, "R3", "write pulse length", we_run, WP);
        chk(mem_dq_oe, "R6", "data hold after we rise", int'(mem_dq_oe), 1);
        chk(mem_addr == p_addr, "R6", "addr hold after we rise", int'(mem_addr), int'(p_addr));
        we_run = 0;
      end
      if (!p_we_n) chk(1'b1, "R3", "ce run tracked", ce_run, ce_run);
      if (!mem_we_n && we_run == WP)
        chk(ce_run == CEW, "R3", "ce low cycles at end of write", ce_run, CEW);
      // R7 read strobe
      if (!mem_oe_n) begin
        oe_run++;
        if (mem_we_n == 1'b0 || mem_dq_oe || mem_ce_n)
          chk(1'b0, "R7", "read strobe set", {mem_ce_n, mem_we_n, mem_dq_oe}, 2);
      end else if (!p_oe_n) begin
        chk(oe_run == ACC, "R7", "read window length", oe_run, ACC);
        oe_run = 0;
      end
      p_ce_n = mem_ce_n; p_we_n = mem_we_n; p_oe_n = mem_oe_n;
      p_addr = mem_addr; p_drive = drive; p_dq_oe = mem_dq_oe;
    end
  end

  // response monitor
  bit p_rsp = 0;
  always @(negedge clk) begin
    if (run_pins) begin
      if (rsp_valid) begin
        rsp_seen++;
        chk(!p_rsp, "R7", "rsp_valid single pulse", 1, 0);
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected response", 1, 0);
        else begin
          logic [DW-1:0] e;
          int            t;
          e = exp_q.pop_front();
          t = t_q.pop_front();
          chk(rsp_rdata == e, "R10", "read data", int'(rsp_rdata), int'(e));
          chk(ncyc - t == ACC + 2, "R7", "read latency", ncyc - t, ACC + 2);
        end
      end
      p_rsp = rsp_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual %0d expected %0d", ncyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes high in reset",
        {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && !rsp_valid, "R1", "no drive, no response", {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
    run_pins = 1'b1;

    // R10 boundary addresses and patterns
    send(1, 19'h00000, 8'h00);
    send(1, 19'h7FFFF, 8'hFF);
    send(1, 19'h12345, 8'hA5);
    send(1, 19'h55555, 8'h5A);
    send(1, 19'h2AAAA, 8'h3C);
    send(0, 19'h00000, 8'h00);
    send(0, 19'h7FFFF, 8'h00);
    send(0, 19'h12345, 8'h00);
    send(0, 19'h55555, 8'h00);
    send(0, 19'h2AAAA, 8'h00);
    // overwrite, then R8 read-to-write turnaround back to back
    send(1, 19'h12345, 8'hC3);
    send(0, 19'h12345, 8'h00);
    send(1, 19'h00000, 8'h11);
    send(0, 19'h00000, 8'h00);
    send(0, 19'h7FFFF, 8'h00);
    send(1, 19'h7FFFF, 8'hEE);
    send(0, 19'h7FFFF, 8'h00);
    for (int i = 0; i < 8; i++) send(1, AW'(i * 4099), DW'(i * 37 + 1));
    for (int i = 7; i >= 0; i--) send(0, AW'(i * 4099), 8'h00);
    // drain
    repeat (ACC + TURN + 6) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "all reads answered", exp_q.size(), 0);
    chk(we_falls == wr_issued, "R2", "one write strobe per write", we_falls, wr_issued);
    chk(rsp_seen == rd_issued, "R2", "one response per read", rsp_seen, rd_issued);
    chk(req_ready, "R2", "ready when idle", int'(req_ready), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule